// File: doc/BRIEF.md
# Serial EEPROM Write-Path Bus Slave

This block is the two-wire bus slave that sits in front of the page buffer of a serial EEPROM and handles only the write direction. It oversamples SCL and SDA with the system clock and detects START and STOP conditions. It compares the first byte with a 7-bit device identifier made of the fixed prefix `1010` and three strap inputs. After a matching write request it collects two address bytes and then any number of data bytes. The slave acknowledges by enabling an open-drain pull-down on SDA.

Each accepted data byte goes to the page buffer as a one-cycle strobe. The strobe carries the byte's 14-bit location. Within a write sequence the page number stays fixed and only the 6-bit byte offset counts up, wrapping inside the 64-byte page. A STOP that follows at least one accepted data byte raises a commit strobe, and the memory side then starts its internal programming cycle. While that cycle runs the memory side holds a busy input high. During that time the slave refuses its own device address, so a bus master can poll for completion.

A write-protect input is captured once per transfer, on the SCL falling edge that ends the acknowledge of the second address byte. If the captured value is high, the first data byte is refused and the transfer produces no buffer writes and no commit.

Top module: `i2c_eeprom_wr_slave`

## Requirements
- R1: The device byte is accepted only when its upper seven bits equal `1010` followed by `dev_sel_i[2:0]` (MSB first) and its last bit (R/W) is 0. Any other device byte gets no acknowledge, and every following byte gets none either until the next START.
- R2: The two bytes after an accepted device byte form a 16-bit address, high byte first. The top two bits are discarded, and `pb_addr_load_o` pulses for one cycle with `pb_addr_o` equal to the low 14 bits.
- R3: An acknowledge means `sda_oe_o` = 1 throughout the ninth SCL high phase of the byte. `sda_oe_o` changes value only while SCL is low.
- R4: Each accepted data byte produces one `pb_wr_o` pulse, with `pb_wdata_o` holding the byte and `pb_addr_o` holding its location. The next location keeps bits 13:6 and increments bits 5:0 modulo 64.
- R5: `pb_commit_o` pulses once on a STOP only if at least one data byte was accepted since the last START. A STOP with no accepted data byte produces no commit.
- R6: A repeated START discards the transfer in progress: no commit follows unless a new data byte is accepted before the next STOP.
- R7: While `wr_busy_i` is 1, a matching device byte gets no acknowledge, and no address load, write or commit follows.
- R8: `wp_i` is captured on the SCL falling edge that ends the second address byte's acknowledge. If it is captured high, the first data byte and all later ones get no acknowledge, no `pb_wr_o` pulse occurs, and STOP gives no commit.
- R9: The value of `wp_i` at any other time has no effect: a high level during the device or address bytes, or after the capture edge, does not block the write.
- R10: A matching device byte with R/W = 1 gets no acknowledge, and nothing is sent to the page buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| dev_sel_i | input | 3 | Low three bits of the device identifier |
| wp_i | input | 1 | Write-protect level |
| wr_busy_i | input | 1 | Internal programming cycle in progress |
| pb_addr_load_o | output | 1 | One-cycle strobe: start address loaded |
| pb_addr_o | output | 14 | Current byte location (page, offset) |
| pb_wr_o | output | 1 | One-cycle strobe: data byte for the page buffer |
| pb_wdata_o | output | 8 | Data byte that goes with `pb_wr_o` |
| pb_commit_o | output | 1 | One-cycle strobe: start the programming cycle |

## Verification
A wrong control state shows at the ports within one byte time. The acknowledge bit of the next byte flips, or a strobe of the wrong kind appears at the next byte boundary. A bad offset counter shows on the second `pb_wr_o` of a sequence, and a page-wrap fault only on the write after offset 63, so a run that starts near the end of a page is required. A stale write-protect capture or a leftover data-seen flag shows as a refused first data byte or as a missing or extra `pb_commit_o`. Each of these appears a few clocks after the STOP.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_IGN
  } wr_state_e;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_sh;
  logic [SYNC_STAGES-1:0] sda_sh;
  logic scl_q, sda_q;

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_sh[i] <= 1'b1;
        sda_sh[i] <= 1'b1;
      end else if (i == 0) begin
        scl_sh[i] <= scl_i;
        sda_sh[i] <= sda_i;
      end else begin
        scl_sh[i] <= scl_sh[(i == 0) ? 0 : i - 1];
        sda_sh[i] <= sda_sh[(i == 0) ? 0 : i - 1];
      end
    end
  end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign sda_s = sda_sh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_page_addr.sv
module i2c_page_addr
  import i2c_wr_pkg::*;
#(
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned OFS_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-BYTE_W-1:0]   hi,
  input  logic [BYTE_W-1:0]          lo,
  input  logic                       adv,
  output logic [ADDR_W-1:0]          addr
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a);
    logic [OFS_W-1:0] ofs;
    ofs = a[OFS_W-1:0] + 1'b1;
    return {a[ADDR_W-1:OFS_W], ofs};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= {hi, lo};
    else if (adv)    addr <= page_next(addr);
  end

  assert_page_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (addr[ADDR_W-1:ADDR_W-PAGE_W] == $past(addr[ADDR_W-1:ADDR_W-PAGE_W])));
endmodule

// File: rtl/i2c_wr_ctrl.sv
module i2c_wr_ctrl
  import i2c_wr_pkg::*;
#(
  parameter int unsigned      ADDR_W     = 14,
  parameter int unsigned      SEL_W      = 3,
  parameter logic [3:0]       DEV_PREFIX = 4'b1010
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_s,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_ev,
  input  logic                     stop_ev,
  input  logic [SEL_W-1:0]         dev_sel,
  input  logic                     wp_i,
  input  logic                     wr_busy_i,
  output logic                     sda_oe,
  output logic                     addr_load_ev,
  output logic [ADDR_W-BYTE_W-1:0] addr_hi,
  output logic [BYTE_W-1:0]        addr_lo,
  output logic                     pb_addr_load_o,
  output logic                     pb_wr_o,
  output logic [BYTE_W-1:0]        pb_wdata_o,
  output logic                     pb_commit_o
);
  localparam int unsigned HI_W = ADDR_W - BYTE_W;

  wr_state_e               st;
  logic [CNT_W-1:0]        bitcnt;
  logic [BYTE_W-1:0]       shreg;
  logic                    ack_phase;
  logic                    wp_lat;
  logic                    wp_pending;
  logic                    data_seen;

  logic shift_ok, byte_done, ack_end, dev_match, dev_ack;
  logic data_ack, data_reject, wp_strobe, commit_ev;

  assign shift_ok   = scl_rise && !ack_phase && (bitcnt < CNT_W'(BYTE_W)) &&
                      (st inside {ST_DEV, ST_AHI, ST_ALO, ST_DATA});
  assign byte_done  = scl_fall && !ack_phase && (bitcnt == CNT_W'(BYTE_W)) &&
                      (st inside {ST_DEV, ST_AHI, ST_ALO, ST_DATA});
  assign ack_end    = scl_fall && ack_phase;
  assign dev_match  = (shreg[BYTE_W-1:1] == {DEV_PREFIX, dev_sel});
  assign dev_ack    = byte_done && (st == ST_DEV) && dev_match && !shreg[0] && !wr_busy_i;
  assign data_ack    = byte_done && (st == ST_DATA) && !wp_lat;
  assign data_reject = byte_done && (st == ST_DATA) && wp_lat;
  assign wp_strobe  = ack_end && wp_pending;
  assign commit_ev  = stop_ev && data_seen;
  assign addr_load_ev = byte_done && (st == ST_ALO);
  assign addr_lo    = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      ack_phase  <= 1'b0;
      sda_oe     <= 1'b0;
      wp_lat     <= 1'b0;
      wp_pending <= 1'b0;
      data_seen  <= 1'b0;
      addr_hi    <= '0;
    end else if (start_ev || stop_ev) begin
      st         <= start_ev ? ST_DEV : ST_IDLE;
      bitcnt     <= '0;
      ack_phase  <= 1'b0;
      sda_oe     <= 1'b0;
      wp_pending <= 1'b0;
      data_seen  <= 1'b0;
    end else begin
      if (shift_ok) begin
        shreg  <= {shreg[BYTE_W-2:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (byte_done) begin
        ack_phase <= 1'b1;
        unique case (st)
          ST_DEV: begin
            if (dev_ack) begin
              sda_oe <= 1'b1;
              st     <= ST_AHI;
            end else begin
              st     <= ST_IGN;
            end
          end
          ST_AHI: begin
            sda_oe  <= 1'b1;
            addr_hi <= shreg[HI_W-1:0];
            st      <= ST_ALO;
          end
          ST_ALO: begin
            sda_oe     <= 1'b1;
            wp_pending <= 1'b1;
            st         <= ST_DATA;
          end
          default: begin
            if (data_reject) begin
              st <= ST_IGN;
            end else begin
              sda_oe    <= 1'b1;
              data_seen <= 1'b1;
            end
          end
        endcase
      end
      if (ack_end) begin
        ack_phase <= 1'b0;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
      end
      if (wp_strobe) begin
        wp_lat     <= wp_i;
        wp_pending <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_addr_load_o <= 1'b0;
      pb_wr_o        <= 1'b0;
      pb_wdata_o     <= '0;
      pb_commit_o    <= 1'b0;
    end else begin
      pb_addr_load_o <= addr_load_ev && !start_ev && !stop_ev;
      pb_wr_o        <= data_ack && !start_ev && !stop_ev;
      pb_commit_o    <= commit_ev;
      if (data_ack) pb_wdata_o <= shreg;
    end
  end

  assert_oe_rise_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
  assert_oe_fall_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_s);
  assert_busy_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == ST_DEV) && wr_busy_i) |=> !sda_oe);
  assert_wp_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wr_o |-> !wp_lat);
  assert_commit_on_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pb_commit_o |-> $past(stop_ev));
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pb_addr_load_o, pb_wr_o, pb_commit_o}));
endmodule

// File: rtl/i2c_eeprom_wr_slave.sv
module i2c_eeprom_wr_slave
  import i2c_wr_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 14,
  parameter int unsigned OFS_W       = 6,
  parameter int unsigned SEL_W       = 3,
  parameter logic [3:0]  DEV_PREFIX  = 4'b1010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [SEL_W-1:0]  dev_sel_i,
  input  logic              wp_i,
  input  logic              wr_busy_i,
  output logic              pb_addr_load_o,
  output logic [ADDR_W-1:0] pb_addr_o,
  output logic              pb_wr_o,
  output logic [BYTE_W-1:0] pb_wdata_o,
  output logic              pb_commit_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic addr_load_ev;
  logic [ADDR_W-BYTE_W-1:0] addr_hi;
  logic [BYTE_W-1:0]        addr_lo;

  i2c_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_wr_ctrl #(
    .ADDR_W     (ADDR_W),
    .SEL_W      (SEL_W),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .scl_s          (scl_s),
    .sda_s          (sda_s),
    .scl_rise       (scl_rise),
    .scl_fall       (scl_fall),
    .start_ev       (start_ev),
    .stop_ev        (stop_ev),
    .dev_sel        (dev_sel_i),
    .wp_i           (wp_i),
    .wr_busy_i      (wr_busy_i),
    .sda_oe         (sda_oe_o),
    .addr_load_ev   (addr_load_ev),
    .addr_hi        (addr_hi),
    .addr_lo        (addr_lo),
    .pb_addr_load_o (pb_addr_load_o),
    .pb_wr_o        (pb_wr_o),
    .pb_wdata_o     (pb_wdata_o),
    .pb_commit_o    (pb_commit_o)
  );

  i2c_page_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_page_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load_ev),
    .hi    (addr_hi),
    .lo    (addr_lo),
    .adv   (pb_wr_o),
    .addr  (pb_addr_o)
  );
endmodule

// File: tb/i2c_eeprom_wr_slave_bench.sv
module i2c_eeprom_wr_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] dev_sel = 3'b010;
  logic wp = 1'b0;
  logic busy = 1'b0;
  logic sda_oe;
  logic pb_addr_load, pb_wr, pb_commit;
  logic [13:0] pb_addr;
  logic [7:0] pb_wdata;
  wire sda_line = sda_m & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_eeprom_wr_slave u_i2c_eeprom_wr_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .dev_sel_i(dev_sel), .wp_i(wp), .wr_busy_i(busy),
    .pb_addr_load_o(pb_addr_load), .pb_addr_o(pb_addr), .pb_wr_o(pb_wr),
    .pb_wdata_o(pb_wdata), .pb_commit_o(pb_commit)
  );

  int pass_n = 0, total_n = 0;
  int wr_n = 0, commit_n = 0, load_n = 0, oe_viol = 0;
  logic [13:0] wr_addr [16];
  logic [7:0]  wr_data [16];
  logic [13:0] last_load = '0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pb_wr) begin
        if (wr_n < 16) begin
          wr_addr[wr_n] = pb_addr;
          wr_data[wr_n] = pb_wdata;
        end
        wr_n++;
      end
      if (pb_commit) commit_n++;
      if (pb_addr_load) begin
        load_n++;
        last_load = pb_addr;
      end
      if (sda_oe != prev_oe && scl_m) oe_viol++;
      prev_oe = sda_oe;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total_n++;
    if (ok) pass_n++;
    else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon();
    wr_n = 0; commit_n = 0; load_n = 0;
  endtask

  task automatic bus_start();
    scl_m = 1'b0; wclk(10); sda_m = 1'b1; wclk(10);
    scl_m = 1'b1; wclk(10); sda_m = 1'b0; wclk(10);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; wclk(10); sda_m = 1'b0; wclk(10);
    scl_m = 1'b1; wclk(10); sda_m = 1'b1; wclk(30);
  endtask

  task automatic send_bit(input bit b);
    scl_m = 1'b0; wclk(10); sda_m = b; wclk(10);
    scl_m = 1'b1; wclk(20);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    scl_m = 1'b0; wclk(10); sda_m = 1'b1; wclk(10);
    scl_m = 1'b1; wclk(2);
    acked = (sda_line == 1'b0);
    wclk(16);
    acked = acked && (sda_line == 1'b0);
    wclk(2);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R3 reset oe", sda_oe, 0);
    check(wr_n == 0 && commit_n == 0 && load_n == 0, "R5 reset strobes", wr_n + commit_n + load_n, 0);
  endtask

  task automatic t_byte_write();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA4, a); check(a, "R1 device ack", a, 1);
    send_byte(8'hC1, a); check(a, "R3 addr hi ack", a, 1);
    send_byte(8'h23, a); check(a, "R3 addr lo ack", a, 1);
    check(load_n == 1 && last_load == 14'h0123, "R2 load top bits dropped", last_load, 14'h0123);
    send_byte(8'h5A, a); check(a, "R3 data ack", a, 1);
    check(commit_n == 0, "R5 no commit before stop", commit_n, 0);
    bus_stop();
    check(commit_n == 1, "R5 commit on stop", commit_n, 1);
    check(wr_n == 1 && wr_addr[0] == 14'h0123 && wr_data[0] == 8'h5A, "R4 byte write",
          {wr_addr[0], wr_data[0]}, {14'h0123, 8'h5A});
  endtask

  task automatic t_page_wrap();
    bit a;
    logic [13:0] exp_a [4] = '{14'h17E, 14'h17F, 14'h140, 14'h141};
    logic [7:0]  exp_d [4] = '{8'h11, 8'h22, 8'h33, 8'h44};
    clear_mon();
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h01, a); send_byte(8'h7E, a);
    for (int i = 0; i < 4; i++) send_byte(exp_d[i], a);
    bus_stop();
    check(wr_n == 4, "R4 wrap count", wr_n, 4);
    for (int i = 0; i < 4; i++)
      check(wr_addr[i] == exp_a[i] && wr_data[i] == exp_d[i], "R4 page wrap",
            {wr_addr[i], wr_data[i]}, {exp_a[i], exp_d[i]});
    check(commit_n == 1, "R5 wrap commit", commit_n, 1);
  endtask

  task automatic t_bad_dev();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA6, a); check(!a, "R1 mismatch nack", a, 0);
    send_byte(8'h00, a); check(!a, "R1 ignored until start", a, 0);
    send_byte(8'h10, a);
    bus_stop();
    check(load_n == 0 && commit_n == 0, "R1 no activity", load_n + commit_n, 0);
    dev_sel = 3'b011;
    bus_start();
    send_byte(8'hA6, a); check(a, "R1 strap select ack", a, 1);
    bus_stop();
    dev_sel = 3'b010;
  endtask

  task automatic t_read();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA5, a); check(!a, "R10 read nack", a, 0);
    send_byte(8'h00, a);
    bus_stop();
    check(load_n == 0 && wr_n == 0, "R10 no buffer activity", load_n + wr_n, 0);
  endtask

  task automatic t_busy();
    bit a;
    clear_mon();
    busy = 1'b1;
    bus_start();
    send_byte(8'hA4, a); check(!a, "R7 busy nack", a, 0);
    send_byte(8'h00, a); send_byte(8'h00, a); send_byte(8'h99, a);
    bus_stop();
    check(load_n == 0 && wr_n == 0 && commit_n == 0, "R7 busy no activity", load_n + wr_n + commit_n, 0);
    busy = 1'b0;
    bus_start();
    send_byte(8'hA4, a); check(a, "R7 ack after busy", a, 1);
    bus_stop();
  endtask

  task automatic t_wp_reject();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h00, a); send_byte(8'h10, a);
    check(a, "R8 addr acked with wp", a, 1);
    wp = 1'b1;
    send_byte(8'hAB, a); check(!a, "R8 first data nack", a, 0);
    wp = 1'b0;
    send_byte(8'hCD, a); check(!a, "R8 later data nack", a, 0);
    bus_stop();
    check(wr_n == 0 && commit_n == 0, "R8 no write no commit", wr_n + commit_n, 0);
  endtask

  task automatic t_wp_window();
    bit a;
    clear_mon();
    wp = 1'b1;
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h00, a); send_byte(8'h20, a);
    wp = 1'b0;
    send_byte(8'h01, a); check(a, "R9 wp before capture ignored", a, 1);
    wp = 1'b1;
    send_byte(8'h02, a); check(a, "R9 wp after capture ignored", a, 1);
    bus_stop();
    wp = 1'b0;
    check(wr_n == 2 && commit_n == 1, "R9 write completes", wr_n * 16 + commit_n, 8'h21);
  endtask

  task automatic t_no_data();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h00, a); send_byte(8'h05, a);
    bus_stop();
    check(load_n == 1 && last_load == 14'h0005, "R2 address only load", last_load, 14'h0005);
    check(commit_n == 0, "R5 no data no commit", commit_n, 0);
  endtask

  task automatic t_rep_start();
    bit a;
    clear_mon();
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h00, a); send_byte(8'h30, a);
    send_byte(8'h77, a);
    bus_start();
    send_byte(8'hA4, a); check(a, "R6 repeated start device ack", a, 1);
    bus_stop();
    check(commit_n == 0, "R6 discarded on restart", commit_n, 0);
    bus_start();
    send_byte(8'hA4, a); send_byte(8'h00, a); send_byte(8'h31, a);
    send_byte(8'h66, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check(commit_n == 1, "R6 stop mid byte keeps completed data", commit_n, 1);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_byte_write();
    t_page_wrap();
    t_bad_dev();
    t_read();
    t_busy();
    t_wp_reject();
    t_wp_window();
    t_no_data();
    t_rep_start();
    check(oe_viol == 0, "R3 oe changes only while scl low", oe_viol, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", pass_n, total_n);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total_n++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", pass_n, total_n);
      $finish;
    end
  end
endmodule